// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is the read side of a synthesizable model of a boot-block flash device. A command decoder outside the block raises single-cycle events: a program has started, an erase has started on a set of blocks, a block is added during the erase window, suspend, resume, completion and failure. The program event comes on the fourth write pulse of its command sequence and the erase event on the sixth. Status polling is valid from the first read after the event.

Each read strobe that has both chip enable and output enable returns one word, registered, on the next clock. The word is either array data from a small register stub or a status word. Which one depends on the operation phase and on whether the read address falls in a block selected for erase.

The status word carries five bits: a data-polling bit (7), an operation toggle bit (6), an error bit (5), an erase-window bit (3) and an erase-block toggle bit (2). Bits 4, 1 and 0 read 0. Block membership comes from the six upper address bits, decoded for a top-boot layout.

Top module: `flash_status_responder`

## Requirements
- R1: A qualified read in the idle phase returns stub data on `rd_data`, with `rd_valid` high, one cycle after the strobe edge. After reset every stub word reads all ones and `rd_valid` is low. The stub word is selected by an XOR fold of every address slice of `STUB_AW` bits, so addresses 0x00003 and 0x00004 select words 3 and 4.
- R2: During a program, every read at any address returns status with bit 7 equal to the complement of bit 7 of the data being written. After completion, the programmed address reads the written data.
- R3: Bit 6 is 0 on the first status read of each operation and inverts on each later qualified status read during program, erase, protected erase or failure. It holds its value on reads during erase suspend.
- R4: During an erase, a status read returns bit 7 = 0, and bits 4, 1 and 0 read 0.
- R5: Bit 3 reads 0 for `ERASE_WIN` cycles after the erase starts or after a block is last added, and 1 after that. Adding a block merges it into the selection only inside the window. Suspend and completion are ignored inside the window.
- R6: Bit 2 inverts on a status read only when the address lies in a selected block. Reads of other blocks leave it unchanged. It reads 0 during a program.
- R7: In suspend, a read in a selected block returns bit 7 = 1 and bit 3 = 1, with bit 6 held and bit 2 toggling. A read of any other block returns array data. Resume returns the block to erase status with bit 6 toggling again.
- R8: A failure event sets bit 5 to 1 in all later status reads. A completion event then returns the block to array reads, and a failed program does not write the stub.
- R9: An erase started with all selected blocks protected returns status with bit 7 = 0 for `PROT_CYC` cycles. After that, reads return array data.
- R10: A strobe without chip enable or without output enable produces no `rd_valid` and does not advance either toggle bit.
- R11: Address bits [17:12] select the block. Values 000xxx to 110xxx are blocks 0 to 6, 1110xx is block 7, 111100 is block 8, 111101 is block 9 and 11111x is block 10. The erase selection masks use bit n for block n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_prog | input | 1 | Program started (accepted in idle) |
| prog_addr | input | ADDR_W | Address being programmed |
| prog_data | input | DATA_W | Data being programmed |
| ev_erase | input | 1 | Erase started (accepted in idle) |
| erase_sel | input | 11 | Blocks selected at erase start |
| erase_prot_all | input | 1 | Every selected block is protected |
| ev_add_blk | input | 1 | Add blocks during the erase window |
| add_sel | input | 11 | Blocks to add |
| ev_suspend | input | 1 | Erase suspend |
| ev_resume | input | 1 | Erase resume |
| ev_done | input | 1 | Operation complete, or leave the error phase |
| ev_fail | input | 1 | Operation failed |
| rd_stb | input | 1 | Read strobe |
| rd_ce | input | 1 | Chip enable qualifier |
| rd_oe | input | 1 | Output enable qualifier |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array data or status word |
| rd_valid | output | 1 | High one cycle after a qualified strobe |

## Verification
A read's word is due one cycle after the edge that samples its strobe. The bench drives every input at a falling edge and samples at the next falling edge, so each word is observed half a cycle after the edge that registers it. An event registered at one edge is seen by a read at the following edge. The erase window and the protected interval are counted in cycles from the event edge, and bit 3 is checked only where that count leaves no doubt. The expected toggle values are tracked read by read from R3 and R6.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int NBLK   = 11;
    localparam int BIDX_W = 4;

    localparam int SB_POLL  = 7;
    localparam int SB_TOG   = 6;
    localparam int SB_ERR   = 5;
    localparam int SB_TIMER = 3;
    localparam int SB_TOG2  = 2;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PROG  = 3'd1,
        PH_ERASE = 3'd2,
        PH_SUSP  = 3'd3,
        PH_PROT  = 3'd4,
        PH_ERR   = 3'd5
    } phase_e;
endpackage

// File: rtl/fsr_block_decode.sv
module fsr_block_decode
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBLK-1:0]   hot
);
    logic [5:0]        hi;
    logic [BIDX_W-1:0] idx;

    assign hi = addr[ADDR_W-1 -: 6];

    // top-boot layout: seven large blocks, then the top eighth split four ways
    always_comb begin
        if (hi[5:3] != 3'b111)        idx = BIDX_W'(hi[5:3]);
        else if (!hi[2])              idx = BIDX_W'(7);
        else if (hi[1:0] == 2'b00)    idx = BIDX_W'(8);
        else if (hi[1:0] == 2'b01)    idx = BIDX_W'(9);
        else                          idx = BIDX_W'(10);
    end

    generate
        for (genvar b = 0; b < NBLK; b++) begin : g_hot
            assign hot[b] = (idx == BIDX_W'(b));
        end
    endgenerate
endmodule

// File: rtl/fsr_array_stub.sv
module fsr_array_stub #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NSL   = (ADDR_W + AW - 1) / AW;
    localparam int PADW  = NSL * AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    function automatic logic [AW-1:0] fold(input logic [ADDR_W-1:0] a);
        logic [PADW-1:0] p;
        logic [AW-1:0]   r;
        p = PADW'(a);
        r = '0;
        for (int i = 0; i < NSL; i++) r = r ^ p[i*AW +: AW];
        return r;
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[fold(waddr)] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[fold(raddr)];
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
    import fsr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int STUB_AW   = 4,
    parameter int ERASE_WIN = 6250,
    parameter int PROT_CYC  = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_prog,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              ev_erase,
    input  logic [NBLK-1:0]   erase_sel,
    input  logic              erase_prot_all,
    input  logic              ev_add_blk,
    input  logic [NBLK-1:0]   add_sel,
    input  logic              ev_suspend,
    input  logic              ev_resume,
    input  logic              ev_done,
    input  logic              ev_fail,
    input  logic              rd_stb,
    input  logic              rd_ce,
    input  logic              rd_oe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CNT_MAX = (ERASE_WIN > PROT_CYC) ? ERASE_WIN : PROT_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e            phase;
        logic [NBLK-1:0]   sel;
        logic [CNT_W-1:0]  cnt;
        logic              expired;
        logic              tog6;
        logic              tog2;
        logic              by_erase;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdat;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } state_t;

    state_t            st_d, st_q;
    logic [NBLK-1:0]   blk_hot;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] stat;
    logic              stub_we;
    logic              rd_q;
    logic              in_sel;
    logic              show_stat;
    logic              adv6;
    logic              adv2;
    phase_e            phase_q;
    logic              expired_q;

    fsr_block_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (rd_addr),
        .hot  (blk_hot)
    );

    fsr_array_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AW(STUB_AW)) u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (stub_we),
        .waddr (st_q.paddr),
        .wdata (st_q.pdat),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        stub_we       = 1'b0;
        rd_q          = rd_stb & rd_ce & rd_oe;
        in_sel        = |(blk_hot & st_q.sel);

        // status word for the current phase
        stat = '0;
        unique case (st_q.phase)
            PH_PROG: begin
                stat[SB_POLL] = ~st_q.pdat[SB_POLL];
                stat[SB_TOG]  = st_q.tog6;
            end
            PH_ERASE: begin
                stat[SB_TOG]   = st_q.tog6;
                stat[SB_TIMER] = st_q.expired;
                stat[SB_TOG2]  = st_q.tog2;
            end
            PH_SUSP: begin
                stat[SB_POLL]  = 1'b1;
                stat[SB_TOG]   = st_q.tog6;
                stat[SB_TIMER] = 1'b1;
                stat[SB_TOG2]  = st_q.tog2;
            end
            PH_PROT: begin
                stat[SB_TOG]  = st_q.tog6;
                stat[SB_TOG2] = st_q.tog2;
            end
            PH_ERR: begin
                stat[SB_POLL]  = st_q.by_erase ? 1'b0 : ~st_q.pdat[SB_POLL];
                stat[SB_TOG]   = st_q.tog6;
                stat[SB_ERR]   = 1'b1;
                stat[SB_TIMER] = st_q.by_erase & st_q.expired;
                stat[SB_TOG2]  = st_q.tog2;
            end
            default: ;
        endcase

        show_stat = (st_q.phase != PH_IDLE) && !((st_q.phase == PH_SUSP) && !in_sel);
        adv6 = (st_q.phase == PH_PROG) || (st_q.phase == PH_ERASE) ||
               (st_q.phase == PH_PROT) || (st_q.phase == PH_ERR);
        adv2 = in_sel && st_q.by_erase &&
               ((st_q.phase == PH_ERASE) || (st_q.phase == PH_SUSP) ||
                (st_q.phase == PH_PROT)  || (st_q.phase == PH_ERR));

        // read path: word out one cycle after the strobe
        if (rd_q) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = show_stat ? stat : arr_rdata;
            if (show_stat && adv6) st_d.tog6 = ~st_q.tog6;
            if (show_stat && adv2) st_d.tog2 = ~st_q.tog2;
        end

        // operation phase events; a new operation clears both toggles
        unique case (st_q.phase)
            PH_IDLE: begin
                if (ev_prog) begin
                    st_d.phase    = PH_PROG;
                    st_d.paddr    = prog_addr;
                    st_d.pdat     = prog_data;
                    st_d.sel      = '0;
                    st_d.tog6     = 1'b0;
                    st_d.tog2     = 1'b0;
                    st_d.by_erase = 1'b0;
                end else if (ev_erase) begin
                    st_d.phase    = erase_prot_all ? PH_PROT : PH_ERASE;
                    st_d.sel      = erase_sel;
                    st_d.cnt      = '0;
                    st_d.expired  = 1'b0;
                    st_d.tog6     = 1'b0;
                    st_d.tog2     = 1'b0;
                    st_d.by_erase = 1'b1;
                end
            end
            PH_PROG: begin
                if (ev_fail) begin
                    st_d.phase = PH_ERR;
                end else if (ev_done) begin
                    st_d.phase = PH_IDLE;
                    stub_we    = 1'b1;
                end
            end
            PH_ERASE: begin
                if (ev_fail) begin
                    st_d.phase = PH_ERR;
                end else if (st_q.expired) begin
                    if (ev_done)         st_d.phase = PH_IDLE;
                    else if (ev_suspend) st_d.phase = PH_SUSP;
                end else if (ev_add_blk) begin
                    st_d.sel = st_q.sel | add_sel;
                    st_d.cnt = '0;
                end else if (st_q.cnt == CNT_W'(ERASE_WIN - 1)) begin
                    st_d.expired = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_SUSP: begin
                if (ev_resume) st_d.phase = PH_ERASE;
            end
            PH_PROT: begin
                if (st_q.cnt == CNT_W'(PROT_CYC - 1)) st_d.phase = PH_IDLE;
                else                                  st_d.cnt   = st_q.cnt + 1'b1;
            end
            PH_ERR: begin
                if (ev_done) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.rd_data;
    assign rd_valid  = st_q.rd_valid;
    assign phase_q   = st_q.phase;
    assign expired_q = st_q.expired;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       rd_ce,
    input logic       rd_oe,
    input logic       ev_fail,
    input phase_e     phase,
    input logic       expired,
    input logic [7:0] rd_data,
    input logic       rd_valid
);
    logic qrd;
    assign qrd = rd_stb && rd_ce && rd_oe;

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        qrd |=> rd_valid);

    p_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !qrd |=> !rd_valid);

    p_poll_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qrd && phase == PH_ERASE) |=> (rd_data[7] == 1'b0));

    p_window_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qrd && phase == PH_ERASE && !expired) |=> (rd_data[3] == 1'b0));

    p_window_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE && !expired && !ev_fail) |=> (phase == PH_ERASE));

    p_err_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (qrd && phase == PH_ERR) |=> rd_data[5]);

    p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (qrd && phase == PH_PROG && $past(qrd && phase == PH_PROG))
        |=> (rd_data[6] != $past(rd_data[6])));
endmodule

bind flash_status_responder fsr_checker u_fsr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .rd_ce    (rd_ce),
    .rd_oe    (rd_oe),
    .ev_fail  (ev_fail),
    .phase    (phase_q),
    .expired  (expired_q),
    .rd_data  (rd_data[7:0]),
    .rd_valid (rd_valid)
);

// File: tb/tb_flash_status_responder.sv
module tb_flash_status_responder;
    localparam int AW = 18;
    localparam int DW = 8;
    localparam int NB = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ev_prog, ev_erase, erase_prot_all, ev_add_blk;
    logic          ev_suspend, ev_resume, ev_done, ev_fail;
    logic [AW-1:0] prog_addr, rd_addr;
    logic [DW-1:0] prog_data;
    logic [NB-1:0] erase_sel, add_sel;
    logic          rd_stb, rd_ce, rd_oe;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_status_responder #(
        .ADDR_W(AW), .DATA_W(DW), .STUB_AW(4), .ERASE_WIN(5), .PROT_CYC(4)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_prog(ev_prog), .prog_addr(prog_addr), .prog_data(prog_data),
        .ev_erase(ev_erase), .erase_sel(erase_sel), .erase_prot_all(erase_prot_all),
        .ev_add_blk(ev_add_blk), .add_sel(add_sel),
        .ev_suspend(ev_suspend), .ev_resume(ev_resume),
        .ev_done(ev_done), .ev_fail(ev_fail),
        .rd_stb(rd_stb), .rd_ce(rd_ce), .rd_oe(rd_oe), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_stb = 1'b1; rd_ce = 1'b1; rd_oe = 1'b1; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        chk("R1 rd_valid after strobe", {31'd0, rd_valid}, 32'd1);
        rd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        chk("R1 reset rd_valid", {31'd0, rd_valid}, 32'd0);
        rst_n = 1'b1;
        idle(1);
        rd(18'h00003, d);
        chk("R1 idle array read", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_program;
        logic [DW-1:0] d;
        prog_addr = 18'h00003; prog_data = 8'h5A; ev_prog = 1'b1;
        @(negedge clk); ev_prog = 1'b0;
        rd(18'h00003, d); chk("R2 R3 program read 1", {24'd0, d}, 32'h80);
        rd(18'h00003, d); chk("R2 R3 program read 2", {24'd0, d}, 32'hC0);
        rd(18'h28000, d); chk("R2 R6 program read other block", {24'd0, d}, 32'h80);
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(18'h00003, d); chk("R2 programmed data", {24'd0, d}, 32'h5A);
        rd(18'h00003, d); chk("R2 data stable", {24'd0, d}, 32'h5A);
    endtask

    task automatic t_erase_suspend;
        logic [DW-1:0] d, e;
        erase_sel = 11'b000_0000_0100; erase_prot_all = 1'b0; ev_erase = 1'b1;
        @(negedge clk); ev_erase = 1'b0;
        rd(18'h10000, d); chk("R4 R5 erase first read", {24'd0, d}, 32'h00);
        add_sel = 11'b010_0000_0000; ev_add_blk = 1'b1;
        @(negedge clk); ev_add_blk = 1'b0;
        ev_suspend = 1'b1; @(negedge clk); ev_suspend = 1'b0;
        rd(18'h3D000, d); chk("R5 R6 added block, suspend in window ignored", {24'd0, d}, 32'h44);
        rd(18'h10000, d); chk("R3 R6 selected block", {24'd0, d & 8'hF7}, 32'h00);
        rd(18'h00000, d); chk("R6 other block holds 1", {24'd0, d & 8'hF7}, 32'h44);
        rd(18'h00000, d); chk("R3 R6 other block holds 2", {24'd0, d & 8'hF7}, 32'h04);
        idle(8);
        rd(18'h10000, d); chk("R4 R5 window expired", {24'd0, d & 8'h88}, 32'h08);
        add_sel = 11'b000_0000_0001; ev_add_blk = 1'b1;
        @(negedge clk); ev_add_blk = 1'b0;
        rd(18'h00000, d); rd(18'h00000, e);
        chk("R5 late add ignored", {31'd0, d[2] ^ e[2]}, 32'd0);
        ev_suspend = 1'b1; @(negedge clk); ev_suspend = 1'b0;
        rd(18'h10000, d); rd(18'h10000, e);
        chk("R7 suspend poll and window bits", {24'd0, d & 8'h88}, 32'h88);
        chk("R7 suspend bit6 held", {31'd0, d[6] ^ e[6]}, 32'd0);
        chk("R7 suspend bit2 toggles", {31'd0, d[2] ^ e[2]}, 32'd1);
        rd(18'h00003, d); chk("R7 suspend other block array", {24'd0, d}, 32'h5A);
        ev_resume = 1'b1; @(negedge clk); ev_resume = 1'b0;
        rd(18'h10000, d); rd(18'h10000, e);
        chk("R7 resume poll low", {31'd0, e[7]}, 32'd0);
        chk("R7 R3 resume bit6 toggles", {31'd0, d[6] ^ e[6]}, 32'd1);
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(18'h10000, d); chk("R1 array after erase", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_decode;
        logic [DW-1:0]  d;
        logic           t2;
        logic [AW-1:0]  addrs [8];
        logic           hit   [8];
        addrs = '{18'h3C000, 18'h3B000, 18'h3D000, 18'h3E000,
                  18'h3F000, 18'h30000, 18'h38000, 18'h3CFFF};
        hit   = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        erase_sel = 11'b101_0000_0000; erase_prot_all = 1'b0; ev_erase = 1'b1;
        @(negedge clk); ev_erase = 1'b0;
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        t2 = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd(addrs[i], d);
            if (i == 0) chk("R5 done in window ignored", {31'd0, d[7]}, 32'd0);
            chk("R11 R6 block decode bit2", {31'd0, d[2]}, {31'd0, t2});
            if (hit[i]) t2 = ~t2;
        end
        idle(8);
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(18'h3C000, d); chk("R11 array after decode erase", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_fail;
        logic [DW-1:0] d;
        prog_addr = 18'h00004; prog_data = 8'h12; ev_prog = 1'b1;
        @(negedge clk); ev_prog = 1'b0;
        ev_fail = 1'b1; @(negedge clk); ev_fail = 1'b0;
        rd(18'h00004, d); chk("R8 error bit read 1", {24'd0, d}, 32'hA0);
        rd(18'h00004, d); chk("R8 R3 error bit read 2", {24'd0, d}, 32'hE0);
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(18'h00004, d); chk("R8 failed program not written", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_protected;
        logic [DW-1:0] d;
        erase_sel = 11'b000_0000_0010; erase_prot_all = 1'b1; ev_erase = 1'b1;
        @(negedge clk); ev_erase = 1'b0; erase_prot_all = 1'b0;
        rd(18'h08001, d); chk("R9 protected erase poll low", {31'd0, d[7]}, 32'd0);
        idle(6);
        rd(18'h08001, d); chk("R9 array after protected interval", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_unqualified;
        logic [DW-1:0] d;
        prog_addr = 18'h00006; prog_data = 8'hFF; ev_prog = 1'b1;
        @(negedge clk); ev_prog = 1'b0;
        rd(18'h00006, d); chk("R3 new operation bit6 starts 0", {24'd0, d}, 32'h00);
        rd_stb = 1'b1; rd_ce = 1'b1; rd_oe = 1'b0; rd_addr = 18'h00006;
        @(negedge clk);
        chk("R10 no valid without oe", {31'd0, rd_valid}, 32'd0);
        rd_ce = 1'b0; rd_oe = 1'b1;
        @(negedge clk);
        chk("R10 no valid without ce", {31'd0, rd_valid}, 32'd0);
        rd_stb = 1'b0;
        rd(18'h00006, d); chk("R10 toggle not advanced", {24'd0, d}, 32'h40);
        ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
        rd(18'h00006, d); chk("R2 completed program", {24'd0, d}, 32'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ev_prog = 1'b0; ev_erase = 1'b0; erase_prot_all = 1'b0; ev_add_blk = 1'b0;
        ev_suspend = 1'b0; ev_resume = 1'b0; ev_done = 1'b0; ev_fail = 1'b0;
        prog_addr = '0; prog_data = '0; erase_sel = '0; add_sel = '0;
        rd_stb = 1'b0; rd_ce = 1'b0; rd_oe = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        t_reset;
        t_program;
        t_erase_suspend;
        t_decode;
        t_fail;
        t_protected;
        t_unqualified;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule